// File: doc/BRIEF.md
# Indirect Codec Register Bridge

This block gives a 32-bit memory-mapped bus access to a small bank of 8-bit codec control registers through two words. The first is a command word that holds a register index, a data byte and a write-request flag. The second is a result word that returns the selected register's value. A host starts a register write by setting the request flag in the command word. That flag stays set as a busy indication until the write lands in the bank. The host reads a register by writing only its index into the command word, waiting a fixed settling period, and then reading the result word.

The register bank lives inside the block. Each entry resets to its own default value. Two indices are holes in the map. Index 0 shows a live status byte from outside and cannot be written. The result word also carries the level of the codec interrupt line, so that line can be polled on the bus.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, the command word (byte offset 0x0) reads 0 and the result word (byte offset 0x4) reads 0 when the interrupt line is low.
- R2: The command word reads back the busy flag in bit 16, the captured register index in bits 14:8 and the captured data byte in bits 7:0. All other bits read 0.
- R3: A bus write to offset 0x0 with bit 16 set, accepted while idle, makes bit 16 read 1 for exactly 4 cycles after the accepting edge. The data byte is written into the indexed entry on the edge where busy clears.
- R4: A bus write to offset 0x0 while busy is ignored. Index, data and busy timing keep the values of the write in progress, and the ignored command writes nothing to the bank.
- R5: Each accepted command restarts the read settle timer. The result byte keeps its previous value for 5 cycles after the accepting edge and shows the indexed entry from the 6th edge on.
- R6: Bit 8 of the result word follows the interrupt input at all times, and bits 31:9 read 0.
- R7: After reset, entries 1 and 2 read 0xC3, entry 3 reads 0x90, entry 4 reads 0x98 and entry 31 reads 0x34. The other entries take their own fixed defaults.
- R8: Entries 5 and 28, and any index from 36 to 127, read 0 and ignore writes.
- R9: Entry 0 reads the status input and ignores writes.
- R10: When a write lands, the read settle timer restarts, so the result byte shows the new value 6 cycles after busy clears.
- R11: Bus writes to offset 0x4 have no effect on the command word, the busy flag or the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid |
| busWe | input | 1 | Bus access is a write |
| busOffset | input | 3 | Byte offset of the word (0x0 command, 0x4 result) |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Read data for busOffset, combinational |
| codecIrq | input | 1 | Codec interrupt request level |
| statusIn | input | 8 | Live status byte shown at entry 0 |

## Verification
A wrong write counter shows up on bit 16 within a few cycles: busy ends early, ends late or restarts when a command arrives during a write. A bad index capture or bank decode shows up in the result byte six cycles after the host selects the entry, because each entry is read back after its write. A read timer that is off by one shows up as the result byte changing one cycle early or late, so the bench checks the cycle before the value is due as well as the cycle it is due.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;

  typedef struct packed {
    logic capture;
    logic startWrite;
    logic commit;
    logic loadOut;
  } bridgeStrobes_t;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      1, 2:           return 8'hC3;
      3, 6:           return 8'h90;
      4:              return 8'h98;
      7:              return 8'hB1;
      8:              return 8'h11;
      9:              return 8'h10;
      11:             return 8'h03;
      14:             return 8'h40;
      16:             return 8'hFF;
      18, 19, 20, 21: return 8'h06;
      31:             return 8'h34;
      32:             return 8'h07;
      33:             return 8'h44;
      34:             return 8'h1F;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic isHole(input int idx);
    return (idx == 5) || (idx == 28);
  endfunction

endpackage

// File: rtl/codec_bridge_ctrl.sv
module codec_bridge_ctrl
  import codec_bridge_pkg::*;
#(
  parameter int WR_CYC = 4,
  parameter int RD_LAT = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdHit,
  input  logic           reqBit,
  output bridgeStrobes_t strb,
  output logic           busy
);
  localparam int WR_CW = $clog2(WR_CYC + 1);
  localparam int RD_CW = $clog2(RD_LAT + 1);

  logic [WR_CW-1:0] wrCnt;
  logic [RD_CW-1:0] rdCnt;

  assign busy = (wrCnt != '0);

  always_comb begin
    strb.capture    = cmdHit && !busy;
    strb.startWrite = strb.capture && reqBit;
    strb.commit     = (wrCnt == WR_CW'(1));
    strb.loadOut    = (rdCnt == RD_CW'(1)) && !strb.capture && !strb.commit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt <= '0;
    end else if (strb.startWrite) begin
      wrCnt <= WR_CW'(WR_CYC);
    end else if (busy) begin
      wrCnt <= wrCnt - WR_CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCnt <= '0;
    end else if (strb.capture || strb.commit) begin
      rdCnt <= RD_CW'(RD_LAT);
    end else if (rdCnt != '0) begin
      rdCnt <= rdCnt - RD_CW'(1);
    end
  end

endmodule

// File: rtl/codec_bridge_dp.sv
module codec_bridge_dp
  import codec_bridge_pkg::*;
#(
  parameter int NUM_REGS = 36,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStrobes_t    strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] statusIn,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [DATA_W-1:0] doutQ
);
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int VIEW_LEN = 2 ** IDX_W;

  logic [DATA_W-1:0] regView [VIEW_LEN];
  logic [DATA_W-1:0] readVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.capture) begin
      addrQ <= cmdAddr;
      dataQ <= cmdData;
    end
  end

  for (genvar i = 0; i < VIEW_LEN; i++) begin : g_entry
    if (i == 0) begin : g_status
      assign regView[i] = statusIn;
    end else if (i >= NUM_REGS || isHole(i)) begin : g_empty
      assign regView[i] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= DATA_W'(regDefault(i));
        end else if (strb.commit && addrQ == ADDR_W'(i)) begin
          q <= dataQ;
        end
      end
      assign regView[i] = q;
    end
  end

  always_comb begin
    if (addrQ < ADDR_W'(NUM_REGS)) begin
      readVal = regView[addrQ[IDX_W-1:0]];
    end else begin
      readVal = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutQ <= '0;
    end else if (strb.loadOut) begin
      doutQ <= readVal;
    end
  end

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int NUM_REGS = 36,
  parameter int WR_CYC   = 4,
  parameter int RD_LAT   = 6,
  parameter int BUS_AW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busOffset,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              codecIrq,
  input  logic [7:0]        statusIn
);
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int REQ_BIT = 16;
  localparam int ADDR_LO = 8;
  localparam logic [BUS_AW-1:0] CMD_OFF  = BUS_AW'(0);
  localparam logic [BUS_AW-1:0] DATA_OFF = BUS_AW'(4);

  bridgeStrobes_t    strb;
  logic              busy;
  logic              cmdHit;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] doutQ;

  assign cmdHit = busSel && busWe && (busOffset == CMD_OFF);

  codec_bridge_ctrl #(
    .WR_CYC(WR_CYC),
    .RD_LAT(RD_LAT)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .cmdHit(cmdHit),
    .reqBit(busWdata[REQ_BIT]),
    .strb  (strb),
    .busy  (busy)
  );

  codec_bridge_dp #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdAddr (busWdata[ADDR_LO+ADDR_W-1:ADDR_LO]),
    .cmdData (busWdata[DATA_W-1:0]),
    .statusIn(statusIn),
    .addrQ   (addrQ),
    .dataQ   (dataQ),
    .doutQ   (doutQ)
  );

  always_comb begin
    if (busOffset == CMD_OFF) begin
      busRdata = {15'd0, busy, 1'b0, addrQ, dataQ};
    end else if (busOffset == DATA_OFF) begin
      busRdata = {23'd0, codecIrq, doutQ};
    end else begin
      busRdata = '0;
    end
  end

endmodule

// File: rtl/codec_reg_bridge_chk.sv
module codec_reg_bridge_chk #(
  parameter int WR_CYC = 4,
  parameter int RD_LAT = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWe,
  input logic [2:0]  busOffset,
  input logic [31:0] busWdata,
  input logic        busy,
  input logic [6:0]  addrQ,
  input logic [7:0]  doutQ
);
  logic       cmdSeen;
  logic [7:0] busyRun;
  logic [7:0] sinceCmd;

  assign cmdSeen = busSel && busWe && (busOffset == 3'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyRun <= '0;
    end else if (busy) begin
      if (busyRun != 8'hFF) busyRun <= busyRun + 8'd1;
    end else begin
      busyRun <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCmd <= 8'hFF;
    end else if (cmdSeen && !busy) begin
      sinceCmd <= 8'd1;
    end else if (sinceCmd != 8'hFF) begin
      sinceCmd <= sinceCmd + 8'd1;
    end
  end

  AST_REQ_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSeen && !busy && busWdata[16]) |=> busy); // R3

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < 8'(WR_CYC))); // R3

  AST_BUSY_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == 8'(WR_CYC))); // R3

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSeen && busy) |=> $stable(addrQ)); // R4

  AST_DOUT_HOLDS_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceCmd >= 8'd1 && sinceCmd <= 8'(RD_LAT)) |-> $stable(doutQ)); // R5

endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(
  .WR_CYC(WR_CYC),
  .RD_LAT(RD_LAT)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWe    (busWe),
  .busOffset(busOffset),
  .busWdata (busWdata),
  .busy     (busy),
  .addrQ    (addrQ),
  .doutQ    (doutQ)
);

// File: tb/codec_reg_bridge_tb.sv
`timescale 1ns/100ps
module codec_reg_bridge_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busOffset = 3'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        codecIrq = 1'b0;
  logic [7:0]  statusIn = 8'h3C;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_reg_bridge u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWe    (busWe),
    .busOffset(busOffset),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .codecIrq (codecIrq),
    .statusIn (statusIn)
  );

  // {index, data written, expected read-back}
  localparam logic [22:0] VEC [7] = '{
    {7'd7,  8'h5A, 8'h5A},
    {7'd31, 8'hA5, 8'hA5},
    {7'd5,  8'h77, 8'h00},
    {7'd28, 8'h12, 8'h00},
    {7'd0,  8'h33, 8'h3C},
    {7'd35, 8'hFF, 8'hFF},
    {7'd40, 8'h11, 8'h00}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] off, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busOffset = off; busWdata = d;
    tick();
    busSel = 1'b0; busWe = 1'b0; busWdata = '0;
  endtask

  task automatic readWord(input logic [2:0] off, output logic [31:0] v);
    busOffset = off;
    #0.1;
    v = busRdata;
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [7:0] d);
    busWrite(3'd0, {15'd0, 1'b1, 1'b0, a, d});
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int n = 0; n < 20; n++) begin
      readWord(3'd0, v);
      if (!v[16]) break;
      tick();
    end
  endtask

  task automatic selectReg(input logic [6:0] a);
    busWrite(3'd0, {15'd0, 1'b0, 1'b0, a, 8'h00});
    repeat (6) tick();
  endtask

  task automatic readReg(input logic [6:0] a, output logic [7:0] d);
    logic [31:0] v;
    selectReg(a);
    readWord(3'd4, v);
    d = v[7:0];
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [7:0]  d;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    readWord(3'd0, v); check("R1 command word", v, 32'h0);
    readWord(3'd4, v); check("R1 result word", v, 32'h0);

    // R5 hold then update, R7 defaults
    busWrite(3'd0, {15'd0, 1'b0, 1'b0, 7'd1, 8'h00});
    repeat (5) tick();
    readWord(3'd4, v); check("R5 result held before settle", v, 32'h0);
    tick();
    readWord(3'd4, v); check("R5 result valid at 6th edge", v, 32'h0C3);
    readReg(7'd2, d);  check("R7 entry 2 default", 32'(d), 32'hC3);
    readReg(7'd3, d);  check("R7 entry 3 default", 32'(d), 32'h90);
    readReg(7'd4, d);  check("R7 entry 4 default", 32'(d), 32'h98);
    readReg(7'd31, d); check("R7 entry 31 default", 32'(d), 32'h34);

    // table of writes and read-backs
    for (int i = 0; i < 7; i++) begin
      logic [6:0] a;
      logic [7:0] wd;
      logic [7:0] ex;
      {a, wd, ex} = VEC[i];
      regWrite(a, wd);
      waitIdle();
      readReg(a, d);
      if (a == 7'd0) check("R9 status entry ignores write", 32'(d), 32'(ex));
      else if (ex == 8'h00 && wd != 8'h00) check("R8 hole/out-of-range entry", 32'(d), 32'(ex));
      else check("R3 written entry read-back", 32'(d), 32'(ex));
    end

    // R2 layout and R3 busy length, R10 reload after commit
    regWrite(7'd10, 8'h99);
    readWord(3'd0, v); check("R2 command layout while busy", v, 32'h0001_0A99);
    for (int k = 0; k < 3; k++) begin
      tick();
      readWord(3'd0, v); check("R3 busy still set", 32'(v[16]), 32'd1);
    end
    tick();
    readWord(3'd0, v); check("R3 busy clears after 4 cycles", v, 32'h0000_0A99);
    repeat (5) tick();
    readWord(3'd4, v); check("R10 result held after commit", v, 32'h0);
    tick();
    readWord(3'd4, v); check("R10 result shows new value", v, 32'h099);

    // R4 command during busy is ignored
    regWrite(7'd11, 8'h22);
    busWrite(3'd0, {15'd0, 1'b1, 1'b0, 7'd12, 8'h44});
    readWord(3'd0, v); check("R4 command kept during busy", v, 32'h0001_0B22);
    tick(); tick();
    readWord(3'd0, v); check("R4 busy not restarted (still set)", 32'(v[16]), 32'd1);
    tick();
    readWord(3'd0, v); check("R4 busy not restarted (clears)", v, 32'h0000_0B22);
    readReg(7'd12, d); check("R4 ignored write did not land", 32'(d), 32'h00);
    readReg(7'd11, d); check("R4 accepted write landed", 32'(d), 32'h22);

    // R11 writes to result word ignored
    busWrite(3'd4, 32'hFFFF_FFFF);
    readWord(3'd0, v); check("R11 command unchanged", v, 32'h0000_0B00);
    repeat (7) tick();
    readWord(3'd4, v); check("R11 result unchanged", v, 32'h022);

    // R6 interrupt mirror
    codecIrq = 1'b1;
    readWord(3'd4, v); check("R6 irq high", v, 32'h122);
    codecIrq = 1'b0;
    readWord(3'd4, v); check("R6 irq low", v, 32'h022);

    // R9 live status
    statusIn = 8'h81;
    readReg(7'd0, d); check("R9 status follows input", 32'(d), 32'h81);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule